// File: doc/BRIEF.md
# Flash Block Erase and Verify Sequencer

This controller erases one block of a modelled flash array and then proves that the erase worked. A start request carries a block index. The controller raises the array's write-enable bit and selects the block with a one-hot mask. It brackets a timed erase pulse between the erase-setup bit and a watchdog enable, and then switches the array into erase-verify mode. The block does not need to be written to zeros before it is erased.

In verify mode the block is walked one 16-bit word at a time, starting from offset zero. Each word gets a dummy write of 0xFF, then a settle wait, then a one-cycle read. A word passes only if all of its bits read as 1. If any word fails, verify mode is left and the erase pulse is repeated. This continues until a configurable attempt limit is reached. Every wait is a parameter counted in clock cycles, and one shared down-counter serves all of them. A run ends with a one-cycle done pulse, and the fail flag is valid in that same cycle. To erase several blocks, the caller issues one request per block.

Top module: `flash_erase_seq`

## Requirements
- R1: A start is accepted only while busy is low and blk_idx < NBLK. Otherwise it has no effect. For the whole accepted run, fl_blksel holds exactly bit blk_idx set.
- R2: Erase phase order and waits. fl_wen rises T_SSWE cycles before fl_esetup and wdt_en rise together. fl_erase rises T_SESU cycles after fl_esetup, and stays high for T_SE cycles. fl_esetup falls T_CE cycles after fl_erase falls. wdt_en falls T_CESU cycles after fl_esetup falls.
- R3: fl_ev rises on the same edge where wdt_en falls. Each word gets a one-cycle fl_wr with fl_wdata = 0xFF, then fl_rd follows 1+T_SEVR cycles after fl_wr. Word offsets on fl_addr run 0, 1, 2, … within each verify pass.
- R4: A word passes only when fl_rdata is 16'hFFFF. Any value with a zero bit, in any bit position, is a miss and ends the verify pass at that word.
- R5: When the last word (offset WORDS-1) passes, fl_ev falls. fl_wen falls T_CEV cycles later. done pulses T_CSWE cycles after that, with fail = 0.
- R6: On a miss, fl_ev falls, and after T_CEV cycles fl_esetup rises again for a new erase pulse, provided fewer than MAX_TRY pulses have been issued.
- R7: A miss after the MAX_TRY-th pulse clears fl_wen T_CEV cycles after fl_ev falls. done then pulses T_CSWE cycles later with fail = 1, so exactly MAX_TRY pulses are issued.
- R8: done is high for exactly one cycle. fail is high only when done is high. busy is low in the done cycle.
- R9: While busy is low, fl_wen, fl_esetup, fl_erase, fl_ev, wdt_en, fl_wr and fl_rd are all 0 and fl_blksel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to erase one block |
| blk_idx | input | BW | Index of the block to erase |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Erase failed; valid with done |
| fl_wen | output | 1 | Array write enable |
| fl_esetup | output | 1 | Erase setup bit |
| fl_erase | output | 1 | Erase pulse bit |
| fl_ev | output | 1 | Erase-verify mode bit |
| fl_blksel | output | NBLK | One-hot block select |
| wdt_en | output | 1 | Watchdog enable during the erase pulse |
| fl_addr | output | AW | Word offset inside the block |
| fl_wr | output | 1 | Dummy-write strobe |
| fl_wdata | output | 8 | Dummy-write data (0xFF while fl_wr) |
| fl_rd | output | 1 | Verify read strobe |
| fl_rdata | input | 16 | Verify read data |

## Verification
A flash model holds one stuck word that keeps reading with a zero bit until a programmed number of erase pulses has been issued. The vector table varies which word is stuck (the first, a middle one, the last), which bit is zero (bit 0, bit 15, all bits), and how many pulses the block needs: zero, one, a few, exactly MAX_TRY, and more than MAX_TRY. Comparing the pulse count and the total number of reads with what the table expects separates three cases: an early pass, a retry, and an exhausted limit. It also shows whether a miss really ends the verify pass at the stuck word. Directed tests cover out-of-range indexes, a start request made during a run, and the spacing of every bit edge.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NBLK    = 6,
  parameter int WORDS   = 16,
  parameter int MAX_TRY = 4,
  parameter int T_SSWE  = 50,
  parameter int T_SESU  = 100,
  parameter int T_SE    = 5000,
  parameter int T_CE    = 50,
  parameter int T_CESU  = 50,
  parameter int T_SEV   = 100,
  parameter int T_SEVR  = 100,
  parameter int T_CEV   = 50,
  parameter int T_CSWE  = 50,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BW-1:0]   blk_idx,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic            fl_wen,
  output logic            fl_esetup,
  output logic            fl_erase,
  output logic            fl_ev,
  output logic [NBLK-1:0] fl_blksel,
  output logic            wdt_en,
  output logic [AW-1:0]   fl_addr,
  output logic            fl_wr,
  output logic [7:0]      fl_wdata,
  output logic            fl_rd,
  input  logic [15:0]     fl_rdata
);
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = mx(mx(mx(T_SSWE, T_SESU), mx(T_SE, T_CE)),
                           mx(mx(T_CESU, T_SEV), mx(mx(T_SEVR, T_CEV), T_CSWE)));
  localparam int CW = $clog2(TMAX + 1);
  localparam int TW = $clog2(MAX_TRY + 1);
  localparam logic [BW:0] NB = NBLK[BW:0];

  typedef enum logic [3:0] {
    IDLE, SWE, ESU, ERS, CE, CESU, EV, DW, RDW, RD, CEVP, CEVF, CSWP, CSWF
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, dn;
  logic [TW-1:0] tries;
  logic [AW-1:0] addr;
  logic [NBLK-1:0] sel;
  logic go;

  assign go = start && ({1'b0, blk_idx} < NB);

  always_comb begin
    case (st)
      SWE:  nxt = ESU;
      ESU:  nxt = ERS;
      ERS:  nxt = CE;
      CE:   nxt = CESU;
      CESU: nxt = EV;
      EV:   nxt = DW;
      DW:   nxt = RDW;
      RDW:  nxt = RD;
      RD:   nxt = !(&fl_rdata) ? CEVF : (addr == AW'(WORDS - 1)) ? CEVP : DW;
      CEVP: nxt = CSWP;
      CEVF: nxt = (tries == TW'(MAX_TRY - 1)) ? CSWF : ESU;
      default: nxt = IDLE;
    endcase
    case (nxt)
      ESU:         dn = CW'(T_SESU - 1);
      ERS:         dn = CW'(T_SE - 1);
      CE:          dn = CW'(T_CE - 1);
      CESU:        dn = CW'(T_CESU - 1);
      EV:          dn = CW'(T_SEV - 1);
      RDW:         dn = CW'(T_SEVR - 1);
      CEVP, CEVF:  dn = CW'(T_CEV - 1);
      CSWP, CSWF:  dn = CW'(T_CSWE - 1);
      default:     dn = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      tries <= '0;
      addr  <= '0;
      sel   <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (st == IDLE) begin
        if (go) begin
          st    <= SWE;
          cnt   <= CW'(T_SSWE - 1);
          sel   <= NBLK'(1) << blk_idx;
          tries <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        st  <= nxt;
        cnt <= dn;
        if (st == CESU) addr <= '0;
        if (st == RD && nxt == DW) addr <= addr + 1'b1;
        if (st == CEVF) tries <= tries + 1'b1;
        if (st == CSWP || st == CSWF) begin
          done <= 1'b1;
          fail <= (st == CSWF);
          sel  <= '0;
        end
      end
    end
  end

  assign busy      = (st != IDLE);
  assign fl_wen    = busy && st != CSWP && st != CSWF;
  assign fl_esetup = st == ESU || st == ERS || st == CE;
  assign fl_erase  = st == ERS;
  assign wdt_en    = fl_esetup || st == CESU;
  assign fl_ev     = st == EV || st == DW || st == RDW || st == RD;
  assign fl_wr     = st == DW;
  assign fl_rd     = st == RD;
  assign fl_wdata  = fl_wr ? 8'hFF : 8'h00;
  assign fl_addr   = addr;
  assign fl_blksel = sel;

  a_r1_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(fl_blksel) == 1);
  a_r1_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fl_blksel));
  a_r2_erase_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> (fl_esetup && fl_wen && wdt_en && !fl_ev));
  a_r3_access_in_ev: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr || fl_rd) |-> (fl_ev && !fl_esetup && !wdt_en));
  a_r3_ff_data: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> fl_wdata == 8'hFF);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && !busy));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fl_wen || fl_ev || wdt_en || fl_wr || fl_rd) && fl_blksel == '0);
endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int CLK_P = 10;
  localparam int NBLK = 6, WORDS = 8, MAX_TRY = 4;
  localparam int T_SSWE = 2, T_SESU = 3, T_SE = 5, T_CE = 2, T_CESU = 2;
  localparam int T_SEV = 3, T_SEVR = 2, T_CEV = 2, T_CSWE = 2;
  localparam int NV = 6;
  // blk, pulses needed, stuck word, miss value, expected fail
  localparam int VEC [NV][5] = '{
    '{2, 1, 3, 'hFFFE, 0},
    '{5, 3, 7, 'h7FFF, 0},
    '{1, 4, 0, 'h0000, 0},
    '{3, 5, 5, 'hFFFE, 1},
    '{4, 0, 2, 'hFFFE, 0},
    '{0, 9, 7, 'hBFFF, 1}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] blk_idx = '0;
  logic busy, done, fail, fl_wen, fl_esetup, fl_erase, fl_ev, wdt_en, fl_wr, fl_rd;
  logic [NBLK-1:0] fl_blksel;
  logic [2:0] fl_addr;
  logic [7:0] fl_wdata;
  logic [15:0] fl_rdata;

  int checks = 0, bad = 0, cyc = 0;
  int pulses = 0, reads = 0, exp_addr = 0;
  int cur_need = 0, cur_badw = 0, cur_mv = 'hFFFF;
  int exp_sel = 0;
  int t_wen_r, t_esu_r, t_ers_r, t_ers_f, t_esu_f, t_ev_f, t_wen_f, t_wr;
  bit first_esu = 1, p_wen = 0, p_esu = 0, p_ers = 0, p_wdt = 0, p_ev = 0;
  bit ended = 0;

  flash_erase_seq #(.NBLK(NBLK), .WORDS(WORDS), .MAX_TRY(MAX_TRY),
    .T_SSWE(T_SSWE), .T_SESU(T_SESU), .T_SE(T_SE), .T_CE(T_CE), .T_CESU(T_CESU),
    .T_SEV(T_SEV), .T_SEVR(T_SEVR), .T_CEV(T_CEV), .T_CSWE(T_CSWE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_idx(blk_idx), .busy(busy),
    .done(done), .fail(fail), .fl_wen(fl_wen), .fl_esetup(fl_esetup),
    .fl_erase(fl_erase), .fl_ev(fl_ev), .fl_blksel(fl_blksel), .wdt_en(wdt_en),
    .fl_addr(fl_addr), .fl_wr(fl_wr), .fl_wdata(fl_wdata), .fl_rd(fl_rd),
    .fl_rdata(fl_rdata));

  assign fl_rdata = (fl_rd && int'(fl_addr) == cur_badw && pulses < cur_need)
                    ? cur_mv[15:0] : 16'hFFFF;

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (fl_wen && !p_wen) t_wen_r = cyc;
    if (fl_esetup && !p_esu) begin
      if (first_esu) chk(cyc - t_wen_r == T_SSWE, "R2 wen->esetup", cyc - t_wen_r, T_SSWE);
      else chk(cyc - t_ev_f == T_CEV, "R6 ev off->re-erase", cyc - t_ev_f, T_CEV);
      first_esu = 0;
      t_esu_r = cyc;
      chk(wdt_en && fl_wen, "R2 wdt with esetup", wdt_en, 1);
    end
    if (fl_erase && !p_ers) begin
      pulses++;
      t_ers_r = cyc;
      chk(cyc - t_esu_r == T_SESU, "R2 esetup->erase", cyc - t_esu_r, T_SESU);
    end
    if (!fl_erase && p_ers) begin
      t_ers_f = cyc;
      chk(cyc - t_ers_r == T_SE, "R2 pulse width", cyc - t_ers_r, T_SE);
    end
    if (!fl_esetup && p_esu) begin
      t_esu_f = cyc;
      chk(cyc - t_ers_f == T_CE, "R2 erase off->esetup off", cyc - t_ers_f, T_CE);
    end
    if (!wdt_en && p_wdt) begin
      chk(cyc - t_esu_f == T_CESU, "R2 esetup off->wdt off", cyc - t_esu_f, T_CESU);
      chk(fl_ev, "R3 ev with wdt off", fl_ev, 1);
      exp_addr = 0;
    end
    if (!fl_ev && p_ev) t_ev_f = cyc;
    if (!fl_wen && p_wen) begin
      t_wen_f = cyc;
      chk(cyc - t_ev_f == T_CEV, "R5/R7 ev off->wen off", cyc - t_ev_f, T_CEV);
    end
    if (fl_wr) begin
      t_wr = cyc;
      chk(fl_wdata == 8'hFF, "R3 dummy data", fl_wdata, 255);
    end
    if (fl_rd) begin
      chk(cyc - t_wr == 1 + T_SEVR, "R3 settle", cyc - t_wr, 1 + T_SEVR);
      chk(int'(fl_addr) == exp_addr, "R3 address walk", fl_addr, exp_addr);
      exp_addr++;
      reads++;
    end
    if (busy && int'(fl_blksel) != exp_sel)
      chk(0, "R1 block select", fl_blksel, exp_sel);
    if (done) chk(cyc - t_wen_f == T_CSWE, "R5/R7 wen off->done", cyc - t_wen_f, T_CSWE);
    p_wen = fl_wen; p_esu = fl_esetup; p_ers = fl_erase; p_wdt = wdt_en; p_ev = fl_ev;
  end

  task automatic run(input int blk, input int need, input int badw, input int mv,
                     input bit efail, input bit poke);
    int ep, er;
    bit got_fail;
    cur_need = need; cur_badw = badw; cur_mv = mv;
    pulses = 0; reads = 0; first_esu = 1;
    exp_sel = 1 << blk;
    @(negedge clk);
    start = 1; blk_idx = 3'(blk);
    @(negedge clk);
    start = 0;
    chk(busy, "R1 start accepted", busy, 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1; blk_idx = 3'((blk + 1) % NBLK);
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    got_fail = fail;
    ep = efail ? MAX_TRY : ((need < 1) ? 1 : need);
    er = efail ? MAX_TRY * (badw + 1) : (ep - 1) * (badw + 1) + WORDS;
    chk(got_fail == efail, efail ? "R7 fail flag" : "R5 pass flag", got_fail, efail);
    chk(pulses == ep, efail ? "R7 pulse count" : "R6 pulse count", pulses, ep);
    chk(reads == er, "R4 read count", reads, er);
    chk(!busy, "R8 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done && !fail, "R8 one-cycle done", done, 0);
    chk(!busy, "R1 busy start ignored", busy, 0);
    chk(!fl_wen && fl_blksel == '0, "R9 idle outputs", fl_blksel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail, "R9 reset status", busy, 0);
    chk(!fl_wen && !fl_ev && !wdt_en && fl_blksel == '0, "R9 reset controls", fl_wen, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4] != 0, 0);

    for (int b = NBLK; b < 8; b++) begin
      start = 1; blk_idx = 3'(b);
      @(negedge clk);
      start = 0;
      @(negedge clk);
      chk(!busy && !fl_wen && fl_blksel == '0, "R1 out-of-range ignored", busy, 0);
    end

    run(1, 1, 4, 'hFFEF, 0, 1);
    run(5, 2, 7, 'hFFFE, 0, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule